// File: doc/BRIEF.md
# Grouped Adjacent Key Suppressor

This block sits behind a bank of capacitive touch channels and decides which of them may report a confirmed touch. Each key arrives with a debounced "wants to detect" flag and an unsigned signal delta that says how strongly it responds. When suppression is active, keys are sorted into domains. In each domain only the strongest candidate is granted detection, so a broad finger on tightly packed keys lights one key instead of several.

Three suppression settings are available: none, three fixed uneven groups, or one domain covering every key. A per-key enable mask removes unused keys from the arbitration completely. A fast-detect input forces suppression off, because fast sliders need several keys active together. A granted key is sticky: it keeps its detection until its own flag drops, even if a neighbour later shows a larger delta. Equal deltas are resolved toward the lower-numbered key.

The outputs are the registered final key states, a detect flag that is the OR of all final states, and a one-cycle change pulse whenever the final state vector differs from the previous cycle.

Top module: `key_suppress_arb`

## Requirements
- R1: While rst_n is low, key_state, any_detect and state_change are all 0.
- R2: With supp_mode = 2'b00 (off), key_state[k] one clock after a sampling edge equals key_want[k] AND key_enable[k] for every k, in any combination.
- R3: With supp_mode = 2'b01 (groups), the keys form three independent domains {0,1,4,5}, {2,3,6,7} and {8,9}, and at most one key per domain is on.
- R4: With supp_mode = 2'b10 (global), all keys form one domain and at most one key is on. supp_mode = 2'b11 behaves as global in the default configuration.
- R5: Among new candidates of one domain with no current holder, the key with the largest unsigned key_delta is granted on the next clock.
- R6: When new candidates in a domain tie on delta, the lowest key index is granted.
- R7: A key with key_enable low is never on and does not block or outrank any other key.
- R8: A key that is on stays on while its want and enable stay high, whatever deltas others in its domain show. No new key in that domain is granted while it holds.
- R9: A key turns off one clock after its want or enable is sampled low. Another candidate in its domain can be granted on that same clock.
- R10: any_detect is the OR of all key_state bits.
- R11: state_change is high for exactly the cycle in which key_state differs from its value one cycle earlier.
- R12: With fast_detect high, the block behaves as in R2 regardless of supp_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_want | input | NUM_KEYS | Debounced per-key request to detect |
| key_delta | input | NUM_KEYS*DELTA_W | Per-key unsigned signal delta, key k at bits [k*DELTA_W +: DELTA_W] |
| key_enable | input | NUM_KEYS | Per-key enable; low marks the key unused |
| supp_mode | input | 2 | 00 off, 01 three groups, 10 global, 11 global (default) |
| fast_detect | input | 1 | Forces suppression off |
| key_state | output | NUM_KEYS | Registered final key states |
| any_detect | output | 1 | OR of all final key states |
| state_change | output | 1 | One-cycle pulse when key_state changed |

## Verification
The directed cases target specific rules. Two keys with different deltas in global mode show that strength decides the winner. Equal deltas show the index tie-break. A strong but disabled key shows that unused keys are excluded from the contest. A late, stronger key next to a holder shows that a grant is sticky, and dropping the holder then shows that the handover happens on the release cycle. In group mode, every key requests at once with rising deltas, so exactly one winner per group appears, and this separates the uneven group partition from a global domain. A long pseudo-random sweep then steps through every combination of mode and fast-detect. Key wants flip rarely, so holds persist and collide with new candidates, and deltas are drawn from a narrow range, so ties are frequent. Each cycle, the state, detect and change outputs are compared against an arithmetic model.

// File: rtl/key_arb_pkg.sv
package key_arb_pkg;

   typedef enum logic [1:0] {
      SUPP_OFF    = 2'b00,
      SUPP_GROUPS = 2'b01,
      SUPP_GLOBAL = 2'b10,
      SUPP_RSVD   = 2'b11
   } supp_mode_e;

   localparam int unsigned FIXED_DOMAINS = 3;

   // Fixed partition: keys 0,1,4,5 -> 0; keys 2,3,6,7 -> 1; keys 8 and up -> 2
   function automatic int unsigned fixed_group(input int unsigned k);
      if (k >= 8) return 2;
      return (k >> 1) & 1;
   endfunction

endpackage

// File: rtl/ksa_domain_map.sv
module ksa_domain_map
   import key_arb_pkg::*;
#(
   parameter int unsigned NUM_KEYS        = 10,
   parameter bit          RSVD_AS_GLOBAL  = 1'b1
) (
   input  logic [1:0]                         supp_mode,
   input  logic                               fast_detect,
   output logic                               suppress_on,
   output logic [NUM_KEYS-1:0][NUM_KEYS-1:0]  same_dom
);

   logic use_groups;
   logic mode_active;

   generate
      if (RSVD_AS_GLOBAL) begin : g_rsvd_global
         assign mode_active = (supp_mode != SUPP_OFF);
      end else begin : g_rsvd_off
         assign mode_active = (supp_mode == SUPP_GROUPS) || (supp_mode == SUPP_GLOBAL);
      end
   endgenerate

   assign use_groups  = (supp_mode == SUPP_GROUPS);
   assign suppress_on = mode_active && !fast_detect;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_row
      for (genvar j = 0; j < NUM_KEYS; j++) begin : g_col
         localparam bit SAME_GRP = (fixed_group(k) == fixed_group(j));
         assign same_dom[k][j] = use_groups ? SAME_GRP : 1'b1;
      end
   end

endmodule

// File: rtl/ksa_strength_rank.sv
module ksa_strength_rank #(
   parameter int unsigned NUM_KEYS = 10,
   parameter int unsigned DELTA_W  = 8
) (
   input  logic [NUM_KEYS-1:0]                cand,
   input  logic [NUM_KEYS-1:0][DELTA_W-1:0]   delta,
   input  logic [NUM_KEYS-1:0][NUM_KEYS-1:0]  same_dom,
   output logic [NUM_KEYS-1:0]                win
);

   logic [NUM_KEYS-1:0][NUM_KEYS-1:0] beaten_by;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      for (genvar j = 0; j < NUM_KEYS; j++) begin : g_rival
         if (j == k) begin : g_self
            assign beaten_by[k][j] = 1'b0;
         end else if (j < k) begin : g_lower
            // lower index wins ties
            assign beaten_by[k][j] = cand[j] && same_dom[k][j] && (delta[j] >= delta[k]);
         end else begin : g_higher
            assign beaten_by[k][j] = cand[j] && same_dom[k][j] && (delta[j] > delta[k]);
         end
      end
      assign win[k] = cand[k] && !(|beaten_by[k]);
   end

endmodule

// File: rtl/ksa_state_track.sv
module ksa_state_track #(
   parameter int unsigned NUM_KEYS = 10
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_KEYS-1:0]                want,
   input  logic [NUM_KEYS-1:0]                en,
   input  logic                               suppress_on,
   input  logic [NUM_KEYS-1:0][NUM_KEYS-1:0]  same_dom,
   input  logic [NUM_KEYS-1:0]                win,
   output logic [NUM_KEYS-1:0]                cand,
   output logic [NUM_KEYS-1:0]                key_state,
   output logic                               state_change
);

   logic [NUM_KEYS-1:0] hold;
   logic [NUM_KEYS-1:0] busy;
   logic [NUM_KEYS-1:0] nxt;

   always_comb begin
      hold = key_state & want & en;
      cand = want & en & ~key_state;
      for (int k = 0; k < NUM_KEYS; k++) begin
         busy[k] = |(hold & same_dom[k]);
      end
      if (suppress_on) nxt = hold | (win & ~busy);
      else             nxt = want & en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_state    <= '0;
         state_change <= 1'b0;
      end else begin
         key_state    <= nxt;
         state_change <= |(nxt ^ key_state);
      end
   end

   logic past_valid;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   // R2 / R12: with suppression off the state follows want AND enable
   p_off_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(!suppress_on) |-> key_state == $past(want & en));

   // R11: change pulse marks a state difference
   p_change_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> state_change == (key_state != $past(key_state)));

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key_chk
      // R8: held key keeps detection
      p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
         past_valid && $past(key_state[k] && want[k] && en[k]) |-> key_state[k]);
      // R7: disabled key is never on
      p_disabled_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
         past_valid && $past(!en[k]) |-> !key_state[k]);
      for (genvar j = k + 1; j < NUM_KEYS; j++) begin : g_pair_chk
         // R3 / R4: two keys of one domain never on together
         p_dom_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid && $past(suppress_on && same_dom[k][j] && !(key_state[k] && key_state[j]))
            |-> !(key_state[k] && key_state[j]));
      end
   end

endmodule

// File: rtl/key_suppress_arb.sv
module key_suppress_arb
   import key_arb_pkg::*;
#(
   parameter int unsigned NUM_KEYS       = 10,
   parameter int unsigned DELTA_W        = 8,
   parameter bit          RSVD_AS_GLOBAL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_KEYS-1:0]           key_want,
   input  logic [NUM_KEYS*DELTA_W-1:0]   key_delta,
   input  logic [NUM_KEYS-1:0]           key_enable,
   input  logic [1:0]                    supp_mode,
   input  logic                          fast_detect,
   output logic [NUM_KEYS-1:0]           key_state,
   output logic                          any_detect,
   output logic                          state_change
);

   localparam int unsigned DELTA_BITS = NUM_KEYS * DELTA_W;

   if (NUM_KEYS < 2 || NUM_KEYS > 16) begin : g_bad_keys
      $error("key_suppress_arb: NUM_KEYS must be in 2..16");
   end
   if (DELTA_W < 1 || DELTA_W > 16) begin : g_bad_delta
      $error("key_suppress_arb: DELTA_W must be in 1..16");
   end
   if (DELTA_BITS != $bits(key_delta)) begin : g_bad_bus
      $error("key_suppress_arb: delta bus width mismatch");
   end

   logic [NUM_KEYS-1:0][DELTA_W-1:0]  delta_arr;
   logic [NUM_KEYS-1:0][NUM_KEYS-1:0] same_dom;
   logic                              suppress_on;
   logic [NUM_KEYS-1:0]               cand;
   logic [NUM_KEYS-1:0]               win;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_unpack
      assign delta_arr[k] = key_delta[k*DELTA_W +: DELTA_W];
   end

   ksa_domain_map #(
      .NUM_KEYS       (NUM_KEYS),
      .RSVD_AS_GLOBAL (RSVD_AS_GLOBAL)
   ) u_map (
      .supp_mode   (supp_mode),
      .fast_detect (fast_detect),
      .suppress_on (suppress_on),
      .same_dom    (same_dom)
   );

   ksa_strength_rank #(
      .NUM_KEYS (NUM_KEYS),
      .DELTA_W  (DELTA_W)
   ) u_rank (
      .cand     (cand),
      .delta    (delta_arr),
      .same_dom (same_dom),
      .win      (win)
   );

   ksa_state_track #(
      .NUM_KEYS (NUM_KEYS)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .want         (key_want),
      .en           (key_enable),
      .suppress_on  (suppress_on),
      .same_dom     (same_dom),
      .win          (win),
      .cand         (cand),
      .key_state    (key_state),
      .state_change (state_change)
   );

   assign any_detect = |key_state;

   // R1: outputs quiet in reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (key_state == '0) && !state_change);

   // R10: detect tracks presence of any active key
   p_detect_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any_detect == ($countones(key_state) != 0));

endmodule

// File: tb/key_suppress_arb_tb_top.sv
module key_suppress_arb_tb_top;

   localparam int N  = 10;
   localparam int DW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    want = '0;
   logic [N*DW-1:0] delta = '0;
   logic [N-1:0]    en = '1;
   logic [1:0]      mode = 2'b00;
   logic            fast = 1'b0;
   logic [N-1:0]    key_state;
   logic            any_detect;
   logic            state_change;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   key_suppress_arb #(.NUM_KEYS(N), .DELTA_W(DW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .key_want     (want),
      .key_delta    (delta),
      .key_enable   (en),
      .supp_mode    (mode),
      .fast_detect  (fast),
      .key_state    (key_state),
      .any_detect   (any_detect),
      .state_change (state_change)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic set_d(input int k, input int v);
      delta[k*DW +: DW] = DW'(v);
   endtask

   function automatic int grp(input int k);
      return (k >= 8) ? 2 : ((k >> 1) & 1);
   endfunction

   function automatic logic [N-1:0] model(input logic [N-1:0] st, input logic [N-1:0] w,
                                          input logic [N-1:0] e, input logic [N*DW-1:0] dv,
                                          input logic [1:0] md, input logic fd);
      logic [N-1:0] hold, cand, nxt;
      if (fd || md == 2'b00) return w & e;
      hold = st & w & e;
      cand = w & e & ~st;
      nxt = hold;
      for (int k = 0; k < N; k++) begin
         bit busy = 0, beaten = 0;
         for (int j = 0; j < N; j++) begin
            bit same = (md == 2'b01) ? (grp(j) == grp(k)) : 1'b1;
            int dj = int'(dv[j*DW +: DW]);
            int dk = int'(dv[k*DW +: DW]);
            if (same) begin
               if (hold[j]) busy = 1;
               if (j != k && cand[j] && (dj > dk || (dj == dk && j < k))) beaten = 1;
            end
         end
         if (cand[k] && !busy && !beaten) nxt[k] = 1'b1;
      end
      return nxt;
   endfunction

   task automatic step;
      @(negedge clk);
   endtask

   task automatic clear;
      want = '0; en = '1; delta = '0;
      step();
      step();
   endtask

   initial begin
      #1_200_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] ms, nx;
      // R1 reset state
      want = '1; mode = 2'b00;
      repeat (3) @(negedge clk);
      chk("R1 state", 32'(key_state), 0);
      chk("R1 detect", 32'(any_detect), 0);
      chk("R1 change", 32'(state_change), 0);
      want = '0;
      rst_n = 1'b1;
      step();

      // R5 / R4 global: stronger key 7 beats key 3
      mode = 2'b10;
      set_d(3, 20); set_d(7, 30);
      want = N'(1 << 3) | N'(1 << 7);
      step();
      chk("R5 strongest", 32'(key_state), 32'(1 << 7));
      chk("R10 detect", 32'(any_detect), 1);
      chk("R11 pulse", 32'(state_change), 1);
      step();
      chk("R11 no pulse", 32'(state_change), 0);
      // R8: stronger key 1 arrives, key 7 keeps it
      set_d(1, 50); want[1] = 1'b1;
      step();
      chk("R8 hold", 32'(key_state), 32'(1 << 7));
      // R9: release 7, key 1 granted same clock
      want[7] = 1'b0;
      step();
      chk("R9 handover", 32'(key_state), 32'(1 << 1));
      clear();
      chk("R9 release", 32'(key_state), 0);
      chk("R10 no detect", 32'(any_detect), 0);

      // R6 tie
      set_d(2, 40); set_d(5, 40);
      want = N'(1 << 2) | N'(1 << 5);
      step();
      chk("R6 tie", 32'(key_state), 32'(1 << 2));
      clear();

      // R7 disabled strong key excluded
      set_d(9, 99); set_d(4, 10);
      en[9] = 1'b0;
      want = N'(1 << 9) | N'(1 << 4);
      step();
      chk("R7 disabled", 32'(key_state), 32'(1 << 4));
      clear();

      // R3 groups, all keys, rising deltas
      mode = 2'b01;
      for (int k = 0; k < N; k++) set_d(k, 10 + k);
      want = '1;
      step();
      chk("R3 groups", 32'(key_state), 32'((1 << 5) | (1 << 7) | (1 << 9)));
      clear();

      // R4 reserved code acts as global
      mode = 2'b11;
      for (int k = 0; k < N; k++) set_d(k, 10 + k);
      want = '1;
      step();
      chk("R4 reserved global", 32'(key_state), 32'(1 << 9));
      clear();

      // R12 fast forces suppression off
      mode = 2'b10; fast = 1'b1;
      want = N'(1 << 0) | N'(1 << 3);
      step();
      chk("R12 fast", 32'(key_state), 32'((1 << 0) | (1 << 3)));
      fast = 1'b0;
      clear();

      // R2 off mode
      mode = 2'b00;
      en = N'(10'b1110111111);
      want = N'(10'b1011011001);
      step();
      chk("R2 off", 32'(key_state), 32'(10'b1010011001));
      clear();

      // sweep over all mode / fast combinations
      ms = '0;
      for (int c = 0; c < 8; c++) begin
         mode = c[1:0];
         fast = c[2];
         for (int i = 0; i < 500; i++) begin
            for (int k = 0; k < N; k++) begin
               if (($urandom % 5) == 0) want[k] = ~want[k];
               if (($urandom % 23) == 0) en[k] = ~en[k];
               set_d(k, int'($urandom % 4));
            end
            nx = model(ms, want, en, delta, mode, fast);
            step();
            if (fast || mode == 2'b00) chk("R2 sweep state", 32'(key_state), 32'(nx));
            else if (mode == 2'b01)    chk("R3 sweep state", 32'(key_state), 32'(nx));
            else                       chk("R4 sweep state", 32'(key_state), 32'(nx));
            chk("R10 sweep detect", 32'(any_detect), 32'(nx != 0));
            chk("R11 sweep change", 32'(state_change), 32'(nx != ms));
            ms = nx;
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule